// File: doc/BRIEF.md
# Sequential Buffer Address Pointer Controller

This block produces the word address for a clocked sequential data port that walks through a buffer of 8192 sixteen-bit words. The address pointer is 13 bits wide. On a rising clock edge it can do one of four things. It can step forward by one. It can take a value from the data bus, one cycle after that value was captured. It can jump to one of two programmable start addresses. Or it can hold.

Two end-of-buffer comparators each watch their own programmable end address. When a step of the pointer lands on that address, the matching active-low flag drops. The flag stays low until software clears it or the block is reset.

A host programs the block through a small command port. The port has three address bits, a read/write strobe and thirteen data bits. Through it the host writes the start and end registers, reads them back, reads the flag register, and writes the control register that clears the flags. The command port is selected by its own enable. It is ignored while the array chip-enable is also asserted.

Top module: `seqptr_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge (synchronous reset), the following take effect on that edge. The pointer goes to 0. Both end flags go high. Both start registers go to 0. Both end registers go to 8191. Any pending delayed load is dropped.
- R2: With no load pending and both start selects high, the pointer steps by one on each rising edge where cnt_en_n is low, whatever the value of ce_n. It holds when cnt_en_n is high.
- R3: A rising edge with ld_n low captures seq_din. On the next rising edge the pointer takes the captured value, and on the capturing edge itself the load does not act.
- R4: A rising edge with strt1_n low (or strt2_n low) loads the pointer from start register 1 (or start register 2). The value used is the one held before that edge.
- R5: When several pointer actions are requested on one edge, they are served in this order: a pending delayed load, then start select 1, then start select 2, then the step. Asserting a start select on the edge where ld_n is low, or on the next edge, is a protocol error.
- R6: End flag k (eob1_n, eob2_n) goes low on the edge where a step makes the pointer equal to end register k. Each flag compares only against its own register.
- R7: Once low, an end flag stays low until it is cleared through the control register or by reset. A step that hits the end address on the same edge as a clear keeps the flag low.
- R8: A delayed load or a start-select load never drives an end flag low, even when the new pointer equals the end address.
- R9: A write happens on an edge with cmd_en_n low, ce_n high and cmd_rw_n low. It stores cmd_wdata at cmd_addr. The addresses are: start register 1 = 3'b000, start register 2 = 3'b001, end register 1 = 3'b010, end register 2 = 3'b011. With cmd_rw_n high instead, cmd_rdata returns the addressed register at once. At the flag register (3'b100), bit 0 is 1 when end flag 1 is low and bit 1 is 1 when end flag 2 is low. All other bits of the flag register read 0, and so do addresses 3'b101 to 3'b111.
- R10: A write to the control register (3'b101) with cmd_wdata bit 0 = 0 clears end flag 1 to high. The same write with bit 1 = 0 clears end flag 2. A 1 in either bit leaves that flag unchanged.
- R11: A step from 8191 wraps the pointer to 0.
- R12: Command writes with ce_n low, and writes to 3'b110 or 3'b111, change no register. cmd_rdata is 0 whenever no command read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequential clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en_n | input | 1 | Step request, active low |
| ld_n | input | 1 | Delayed-load capture request, active low |
| strt1_n | input | 1 | Jump to start register 1, active low |
| strt2_n | input | 1 | Jump to start register 2, active low |
| seq_din | input | 13 | Address bits of the sequential data bus |
| ce_n | input | 1 | Array chip-enable, active low; blocks command access |
| cmd_en_n | input | 1 | Command port select, active low |
| cmd_rw_n | input | 1 | Command direction: 1 read, 0 write |
| cmd_addr | input | 3 | Command register address |
| cmd_wdata | input | 13 | Command write data |
| cmd_rdata | output | 13 | Command read data |
| ptr | output | 13 | Current buffer word address |
| eob1_n | output | 1 | End-of-buffer flag 1, active low |
| eob2_n | output | 1 | End-of-buffer flag 2, active low |

## Verification
The pointer is visible at the ports, so a wrong priority choice or a lost pending load shows on ptr one edge after the request. A load that lands one cycle early or late shows up on the edge in question. A corrupted start or end register stays hidden until a later jump or an end flag shows it. That register is therefore read back through the command port, and a jump or a flag hit then exposes it within a few cycles. Flag state that leaks (set by a load, or lost on a clear that races a hit) shows on eob1_n or eob2_n on the next edge. It is also checked through the flag register read.

// File: rtl/seqptr_pkg.sv
`timescale 1ns/1ps
// Package seqptr_pkg
// Shared sizes and command-register addresses for the sequential buffer
// address pointer controller. Assumes two buffers (two start and two end
// registers), so the command map fits in three address bits.
package seqptr_pkg;
    localparam int SP_PTR_W  = 13;
    localparam int SP_NBUF   = 2;
    localparam int SP_CMD_AW = 3;

    // Command map: start k at k, end k at NBUF+k, flags, then control.
    localparam logic [SP_CMD_AW-1:0] SP_A_FLAGS = SP_CMD_AW'(2 * SP_NBUF);
    localparam logic [SP_CMD_AW-1:0] SP_A_CTRL  = SP_CMD_AW'(2 * SP_NBUF + 1);
endpackage

// File: rtl/seqptr_cmdregs.sv
`timescale 1ns/1ps
// Module seqptr_cmdregs
// Command register file. It holds NBUF start registers and NBUF end
// registers, decodes control-register clear strobes, and muxes read data.
// Assumes acc_en is already qualified by the port select and the
// array-enable interlock.
module seqptr_cmdregs #(
    parameter int PTR_W  = 13,
    parameter int NBUF   = 2,
    parameter int CMD_AW = 3,
    parameter logic [CMD_AW-1:0] A_FLAGS = CMD_AW'(4),
    parameter logic [CMD_AW-1:0] A_CTRL  = CMD_AW'(5)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_en,
    input  logic                        rw_n,
    input  logic [CMD_AW-1:0]           addr,
    input  logic [PTR_W-1:0]            wdata,
    input  logic [NBUF-1:0]             flags_set,
    output logic [NBUF-1:0][PTR_W-1:0]  start_q,
    output logic [NBUF-1:0][PTR_W-1:0]  end_q,
    output logic [NBUF-1:0]             clr,
    output logic [PTR_W-1:0]            rdata
);
    logic wr_en;
    logic rd_en;

    assign wr_en = acc_en & ~rw_n;
    assign rd_en = acc_en & rw_n;

    // Store start/end registers on a command write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '1;
        end else if (wr_en) begin
            for (int k = 0; k < NBUF; k++) begin
                if (addr == CMD_AW'(k))
                    start_q[k] <= wdata;
                if (addr == CMD_AW'(NBUF + k))
                    end_q[k] <= wdata;
            end
        end
    end

    // Clear strobes: a zero in bit k of a control write clears flag k.
    always_comb begin
        for (int k = 0; k < NBUF; k++)
            clr[k] = wr_en && (addr == A_CTRL) && !wdata[k];
    end

    // Read mux: registers, flag register, zero elsewhere or when idle.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int k = 0; k < NBUF; k++) begin
                if (addr == CMD_AW'(k))
                    rdata = start_q[k];
                if (addr == CMD_AW'(NBUF + k))
                    rdata = end_q[k];
            end
            if (addr == A_FLAGS)
                rdata = PTR_W'(flags_set);
        end
    end
endmodule

// File: rtl/seqptr_pointer.sv
`timescale 1ns/1ps
// Module seqptr_pointer
// Address pointer with a one-cycle delayed load from the data bus,
// NBUF start-address jumps and a wrapping step. Priority: pending load,
// then start selects (lowest index first), then step. Exports the next
// value and a step indication so that the end comparators can match.
module seqptr_pointer #(
    parameter int PTR_W = 13,
    parameter int NBUF  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cnt_en_n,
    input  logic                        ld_n,
    input  logic [NBUF-1:0]             strt_n,
    input  logic [PTR_W-1:0]            ld_data,
    input  logic [NBUF-1:0][PTR_W-1:0]  start_q,
    output logic [PTR_W-1:0]            ptr_q,
    output logic [PTR_W-1:0]            ptr_nxt,
    output logic                        inc_fire,
    output logic                        ld_pend
);
    logic [PTR_W-1:0] dreg_q;

    // Select the next pointer value by the fixed action priority.
    always_comb begin
        inc_fire = 1'b0;
        ptr_nxt  = ptr_q;
        if (ld_pend) begin
            ptr_nxt = dreg_q;
        end else if (~&strt_n) begin
            for (int k = NBUF - 1; k >= 0; k--)
                if (!strt_n[k])
                    ptr_nxt = start_q[k];
        end else if (!cnt_en_n) begin
            ptr_nxt  = ptr_q + PTR_W'(1);
            inc_fire = 1'b1;
        end
    end

    // Update the pointer and the delayed-load capture stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            dreg_q  <= '0;
            ld_pend <= 1'b0;
        end else begin
            ptr_q   <= ptr_nxt;
            ld_pend <= ~ld_n;
            if (!ld_n)
                dreg_q <= ld_data;
        end
    end
endmodule

// File: rtl/seqptr_endflag.sv
`timescale 1ns/1ps
// Module seqptr_endflag
// One sticky active-low end-of-buffer flag. It is set only when a step
// makes the pointer equal to the end value, and cleared by a strobe.
// A hit on the same edge as a clear wins.
module seqptr_endflag #(
    parameter int PTR_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_fire,
    input  logic [PTR_W-1:0] ptr_nxt,
    input  logic [PTR_W-1:0] end_val,
    input  logic             clr,
    output logic             flag_n
);
    logic hit;

    assign hit = inc_fire && (ptr_nxt == end_val);

    // Hold the flag low from a step hit until a clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_n <= 1'b1;
        else if (hit)
            flag_n <= 1'b0;
        else if (clr)
            flag_n <= 1'b1;
    end
endmodule

// File: rtl/seqptr_ctrl.sv
`timescale 1ns/1ps
// Module seqptr_ctrl
// Top of the sequential buffer address pointer controller. It joins the
// command register file, the pointer and one end flag per buffer.
// Assumes the host never selects the command port and the array at once.
// Such an access is ignored.
module seqptr_ctrl
    import seqptr_pkg::*;
#(
    parameter int PTR_W  = SP_PTR_W,
    parameter int CMD_AW = SP_CMD_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en_n,
    input  logic              ld_n,
    input  logic              strt1_n,
    input  logic              strt2_n,
    input  logic [PTR_W-1:0]  seq_din,
    input  logic              ce_n,
    input  logic              cmd_en_n,
    input  logic              cmd_rw_n,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [PTR_W-1:0]  cmd_wdata,
    output logic [PTR_W-1:0]  cmd_rdata,
    output logic [PTR_W-1:0]  ptr,
    output logic              eob1_n,
    output logic              eob2_n
);
    localparam int NBUF = SP_NBUF;

    logic [NBUF-1:0][PTR_W-1:0] st_q;
    logic [NBUF-1:0][PTR_W-1:0] end_q;
    logic [NBUF-1:0]            clr_vec;
    logic [NBUF-1:0]            eob_vec;
    logic [NBUF-1:0]            strt_vec;
    logic [PTR_W-1:0]           ptr_nxt;
    logic                       inc_fire;
    logic                       ld_pend;
    logic                       acc_en;

    assign acc_en   = ~cmd_en_n & ce_n;
    assign strt_vec = {strt2_n, strt1_n};
    assign eob1_n   = eob_vec[0];
    assign eob2_n   = eob_vec[1];

    seqptr_cmdregs #(
        .PTR_W(PTR_W), .NBUF(NBUF), .CMD_AW(CMD_AW),
        .A_FLAGS(CMD_AW'(SP_A_FLAGS)), .A_CTRL(CMD_AW'(SP_A_CTRL))
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .rw_n(cmd_rw_n),
        .addr(cmd_addr), .wdata(cmd_wdata), .flags_set(~eob_vec),
        .start_q(st_q), .end_q(end_q), .clr(clr_vec), .rdata(cmd_rdata)
    );

    seqptr_pointer #(.PTR_W(PTR_W), .NBUF(NBUF)) u_ptr (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
        .strt_n(strt_vec), .ld_data(seq_din), .start_q(st_q),
        .ptr_q(ptr), .ptr_nxt(ptr_nxt), .inc_fire(inc_fire), .ld_pend(ld_pend)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_eob
        seqptr_endflag #(.PTR_W(PTR_W)) u_flag (
            .clk(clk), .rst_n(rst_n), .inc_fire(inc_fire), .ptr_nxt(ptr_nxt),
            .end_val(end_q[g]), .clr(clr_vec[g]), .flag_n(eob_vec[g])
        );
    end
endmodule

// File: rtl/seqptr_ctrl_chk.sv
`timescale 1ns/1ps
// Module seqptr_ctrl_chk
// Property checker for seqptr_ctrl, bound to every instance of it.
module seqptr_ctrl_chk #(
    parameter int PTR_W = 13
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cnt_en_n,
    input logic                   ld_n,
    input logic                   strt1_n,
    input logic                   strt2_n,
    input logic [PTR_W-1:0]       seq_din,
    input logic [PTR_W-1:0]       ptr,
    input logic                   eob1_n,
    input logic                   eob2_n,
    input logic                   ld_pend,
    input logic [1:0][PTR_W-1:0]  st_vec,
    input logic                   inc_fire,
    input logic [1:0]             clr_vec
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ptr == '0 && eob1_n && eob2_n));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_pend && strt1_n && strt2_n && !cnt_en_n) |=> ptr == $past(ptr) + PTR_W'(1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_pend && strt1_n && strt2_n && cnt_en_n) |=> $stable(ptr));

    // R3
    delayed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n |-> ##2 ptr == $past(seq_din, 2));

    // R4
    start1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_pend && !strt1_n) |=> ptr == $past(st_vec[0]));

    // R5
    start2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_pend && strt1_n && !strt2_n) |=> ptr == $past(st_vec[1]));

    // R7
    flag1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eob1_n && !clr_vec[0]) |=> !eob1_n);

    // R7
    flag2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eob2_n && !clr_vec[1]) |=> !eob2_n);

    // R8
    flag1_only_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eob1_n && !inc_fire) |=> eob1_n);

    // R8
    flag2_only_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eob2_n && !inc_fire) |=> eob2_n);
endmodule

bind seqptr_ctrl seqptr_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
    .strt1_n(strt1_n), .strt2_n(strt2_n), .seq_din(seq_din), .ptr(ptr),
    .eob1_n(eob1_n), .eob2_n(eob2_n), .ld_pend(ld_pend), .st_vec(st_q),
    .inc_fire(inc_fire), .clr_vec(clr_vec)
);

// File: tb/seqptr_ctrl_tb.sv
`timescale 1ns/1ps
// Bench seqptr_ctrl_tb
// Scoreboard bench. The driver task applies one cycle of stimulus and
// pushes the expected pointer and flags, computed from the requirements.
// The monitor pops and compares after each rising edge.
module seqptr_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en_n = 1'b1, ld_n = 1'b1, strt1_n = 1'b1, strt2_n = 1'b1;
    logic [12:0] seq_din = '0;
    logic        ce_n = 1'b1, cmd_en_n = 1'b1, cmd_rw_n = 1'b1;
    logic [2:0]  cmd_addr = '0;
    logic [12:0] cmd_wdata = '0;
    logic [12:0] cmd_rdata, ptr;
    logic        eob1_n, eob2_n;

    int checks = 0;
    int bad = 0;
    int proto_err = 0;

    typedef struct {
        logic [12:0] p;
        logic        e1;
        logic        e2;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // Bench model state
    logic [12:0] m_ptr, m_dreg, m_s1, m_s2, m_e1, m_e2;
    logic        m_pend, m_f1, m_f2;

    always #10 clk = ~clk;

    seqptr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_n(cnt_en_n), .ld_n(ld_n),
        .strt1_n(strt1_n), .strt2_n(strt2_n), .seq_din(seq_din), .ce_n(ce_n),
        .cmd_en_n(cmd_en_n), .cmd_rw_n(cmd_rw_n), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .ptr(ptr),
        .eob1_n(eob1_n), .eob2_n(eob2_n)
    );

    // Driver: one clock of stimulus plus the expected post-edge state.
    task automatic cyc(input logic cen, input logic ldn, input logic s1n,
                       input logic s2n, input logic [12:0] din,
                       input logic cmdn, input logic arr_n, input logic rwn,
                       input logic [2:0] a, input logic [12:0] wd,
                       input string tag);
        logic [12:0] nptr;
        logic        inc, wr;
        exp_t        it;
        cnt_en_n = cen; ld_n = ldn; strt1_n = s1n; strt2_n = s2n;
        seq_din = din; cmd_en_n = cmdn; ce_n = arr_n; cmd_rw_n = rwn;
        cmd_addr = a; cmd_wdata = wd;
        if (rst_n && (!s1n || !s2n) && (!ldn || m_pend)) begin
            proto_err++;
            $display("FAIL R5 protocol: start select during load window");
        end
        if (!rst_n) begin
            m_ptr = '0; m_dreg = '0; m_pend = 1'b0; m_s1 = '0; m_s2 = '0;
            m_e1 = 13'd8191; m_e2 = 13'd8191; m_f1 = 1'b1; m_f2 = 1'b1;
        end else begin
            inc = 1'b0;
            wr = !cmdn && arr_n && !rwn;
            if (m_pend) nptr = m_dreg;
            else if (!s1n) nptr = m_s1;
            else if (!s2n) nptr = m_s2;
            else if (!cen) begin nptr = m_ptr + 13'd1; inc = 1'b1; end
            else nptr = m_ptr;
            if (inc && nptr == m_e1) m_f1 = 1'b0;
            else if (wr && a == 3'd5 && !wd[0]) m_f1 = 1'b1;
            if (inc && nptr == m_e2) m_f2 = 1'b0;
            else if (wr && a == 3'd5 && !wd[1]) m_f2 = 1'b1;
            m_pend = !ldn;
            if (!ldn) m_dreg = din;
            if (wr) begin
                case (a)
                    3'd0: m_s1 = wd;
                    3'd1: m_s2 = wd;
                    3'd2: m_e1 = wd;
                    3'd3: m_e2 = wd;
                    default: ;
                endcase
            end
            m_ptr = nptr;
        end
        it.p = m_ptr; it.e1 = m_f1; it.e2 = m_f2; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 0, 1, 1, 1, 0, 0, tag);
    endtask

    task automatic step(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 1, 1, 1, 0, 1, 1, 1, 0, 0, tag);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [12:0] d, input string tag);
        cyc(1, 1, 1, 1, 0, 0, 1, 0, a, d, tag);
    endtask

    // Command read: check cmd_rdata against the model, then run the cycle.
    task automatic rreg(input logic [2:0] a, input string tag);
        logic [12:0] e;
        case (a)
            3'd0: e = m_s1;
            3'd1: e = m_s2;
            3'd2: e = m_e1;
            3'd3: e = m_e2;
            3'd4: e = {11'd0, ~m_f2, ~m_f1};
            default: e = '0;
        endcase
        cmd_en_n = 1'b0; ce_n = 1'b1; cmd_rw_n = 1'b1; cmd_addr = a;
        #1;
        checks++;
        if (cmd_rdata !== e) begin
            bad++;
            $display("FAIL %s: read addr %0d cmd_rdata=%0d expected %0d", tag, a, cmd_rdata, e);
        end
        cyc(1, 1, 1, 1, 0, 0, 1, 1, a, 0, tag);
    endtask

    // Monitor: compare each expected item after its rising edge.
    always @(negedge clk) begin
        exp_t it;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            checks++;
            if (ptr !== it.p || eob1_n !== it.e1 || eob2_n !== it.e2) begin
                bad++;
                $display("FAIL %s: ptr=%0d eob1_n=%b eob2_n=%b expected ptr=%0d eob1_n=%b eob2_n=%b",
                         it.tag, ptr, eob1_n, eob2_n, it.p, it.e1, it.e2);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #4000000;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state and register defaults
        cyc(1, 1, 1, 1, 0, 1, 1, 1, 0, 0, "R1");
        cyc(0, 1, 1, 1, 0, 1, 1, 1, 0, 0, "R1");
        rst_n = 1'b1;
        rreg(3'd2, "R1");
        rreg(3'd1, "R1");
        // R2: step, hold, step with the array enabled
        step(5, "R2");
        idle(3, "R2");
        cyc(0, 1, 1, 1, 0, 1, 0, 1, 0, 0, "R2");
        cyc(0, 1, 1, 1, 0, 1, 0, 1, 0, 0, "R2");
        // R3: delayed load, single and back to back
        cyc(0, 0, 1, 1, 13'd100, 1, 1, 1, 0, 0, "R3");
        step(2, "R3");
        cyc(1, 0, 1, 1, 13'd200, 1, 1, 1, 0, 0, "R3");
        cyc(1, 0, 1, 1, 13'd300, 1, 1, 1, 0, 0, "R3");
        idle(2, "R3");
        // R9 / R4 / R5: program starts, jump, priority
        wreg(3'd0, 13'd500, "R9");
        wreg(3'd1, 13'd7000, "R9");
        rreg(3'd0, "R9");
        rreg(3'd1, "R9");
        cyc(1, 1, 0, 1, 0, 1, 1, 1, 0, 0, "R4");
        cyc(0, 1, 1, 0, 0, 1, 1, 1, 0, 0, "R5");
        cyc(0, 1, 0, 0, 0, 1, 1, 1, 0, 0, "R5");
        // R6 / R7: end flag 1 hit by stepping, then sticky
        wreg(3'd2, 13'd505, "R9");
        step(5, "R6");
        step(3, "R7");
        rreg(3'd4, "R9");
        // R8: load onto end address 2 does not set flag 2
        wreg(3'd3, 13'd20, "R9");
        cyc(1, 0, 1, 1, 13'd20, 1, 1, 1, 0, 0, "R8");
        idle(2, "R8");
        cyc(1, 1, 0, 1, 0, 1, 1, 1, 0, 0, "R8");
        // R10: clear flag 1, set flag 2, no-op clear, real clear
        wreg(3'd5, 13'h1FFE, "R10");
        cyc(1, 0, 1, 1, 13'd19, 1, 1, 1, 0, 0, "R10");
        idle(1, "R10");
        step(1, "R6");
        rreg(3'd4, "R9");
        wreg(3'd5, 13'h1FFF, "R10");
        wreg(3'd5, 13'h1FFD, "R10");
        // R7: hit on the same edge as a clear keeps flag 1 low
        cyc(1, 0, 1, 1, 13'd504, 1, 1, 1, 0, 0, "R7");
        idle(1, "R7");
        step(1, "R7");
        cyc(1, 0, 1, 1, 13'd504, 1, 1, 1, 0, 0, "R7");
        idle(1, "R7");
        cyc(0, 1, 1, 1, 0, 0, 1, 0, 3'd5, 13'h1FFE, "R7");
        rreg(3'd4, "R7");
        // R11: wrap from 8191 to 0
        wreg(3'd1, 13'd8190, "R11");
        cyc(1, 1, 1, 0, 0, 1, 1, 1, 0, 0, "R11");
        step(3, "R11");
        // R12: ignored writes and idle read data
        cyc(1, 1, 1, 1, 0, 0, 0, 0, 3'd0, 13'd123, "R12");
        wreg(3'd6, 13'd77, "R12");
        wreg(3'd7, 13'd55, "R12");
        rreg(3'd0, "R12");
        rreg(3'd6, "R12");
        rreg(3'd5, "R12");
        cmd_en_n = 1'b1; cmd_rw_n = 1'b1; cmd_addr = 3'd0;
        #1;
        checks++;
        if (cmd_rdata !== 13'd0) begin
            bad++;
            $display("FAIL R12: idle cmd_rdata=%0d expected 0", cmd_rdata);
        end
        // R1: reset in the middle of a run
        rst_n = 1'b0;
        cyc(0, 1, 1, 1, 0, 1, 1, 1, 0, 0, "R1");
        rst_n = 1'b1;
        rreg(3'd1, "R1");
        rreg(3'd4, "R1");
        idle(2, "R1");
        // R5: the stimulus kept out of the load window
        checks++;
        if (proto_err != 0) begin
            bad++;
            $display("FAIL R5: protocol errors=%0d expected 0", proto_err);
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule